// File: doc/BRIEF.md
# Network Interface Packetizer for an On-Chip Network

This block connects a processing core to one link of an on-chip network. The core sees a transaction port and knows nothing of the network topology. It presents a command, a destination node, a target-local address, a burst tag, a packet index and up to `MAX_BEATS` data words. The block looks up the full path to that destination in a small fixed route table. It then emits the packet as 32-bit flits: a header flit, an address flit and the data words, with a tail flag on the final flit. Because the route is in the header, switches downstream only consume hop selectors and never compute paths.

The return direction is independent of the request direction. Incoming flits are gathered in order into a response: first a header, then data words, ending at the tail flag. The response is offered to the core only once the tail has arrived. A small counter caps the number of requests in flight at `MAX_OUT`. Every stream edge (request, outgoing link, incoming link, response) uses valid/ready. A transfer happens in a cycle where both are high. A source holding valid must keep its payload unchanged until ready is seen, and the block's own outputs follow that rule too.

Top module: `noc_ni_pkt`

## Requirements
- R1: Right after reset, `req_ready` is 1, `out_valid` is 0, `rsp_valid` is 0 and `in_ready` is 1.
- R2: The first flit of every packet is the header: bits [7:0] route, [10:8] destination, [13:11] source (`NODE_ID`), [15:14] command, [19:16] burst tag, [23:20] packet index, [26:24] data word count, [31:27] zero. The route holds four 2-bit hop selectors with hop k at bits [2k+1:2k], and for destination d hop k equals (d + k) mod 4.
- R3: The second flit is the request address. It is followed by exactly `req_len` data flits (0 to `MAX_BEATS`), taken from `req_data` word 0 upward, where word i is bits [32i+31:32i].
- R4: `out_last` is 1 on the final flit of a packet and 0 on every other flit. `out_valid` falls in the cycle after the final flit is taken.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_flit` and `out_last` hold their values.
- R6: `req_ready` is 0 while a packet is being sent, so a new request is taken only once the link side is idle.
- R7: At most `MAX_OUT` (4) requests are outstanding. With that many in flight `req_ready` stays 0 until a response is delivered to the core.
- R8: When a request is accepted and a response is delivered in the same cycle, the outstanding count is unchanged.
- R9: `rsp_valid` rises only after the flit carrying `in_last` is taken. `rsp_hdr` is the first flit of that packet, and `rsp_len` is the number of following data flits.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `in_ready` is 0 and the response outputs hold their values.
- R11: Response data flits beyond `MAX_BEATS` are dropped. `rsp_len` saturates at `MAX_BEATS` and the stored words are the first ones received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken when high with valid |
| req_cmd | input | 2 | Command code |
| req_dest | input | 3 | Destination node |
| req_bid | input | 4 | Burst tag |
| req_pidx | input | 4 | Packet index within message |
| req_addr | input | 32 | Target-local address |
| req_len | input | 3 | Number of data words |
| req_data | input | 128 | Data words, word 0 lowest |
| out_valid | output | 1 | Flit offered to switch |
| out_ready | input | 1 | Switch takes flit |
| out_flit | output | 32 | Outgoing flit |
| out_last | output | 1 | Tail flag of outgoing flit |
| in_valid | input | 1 | Incoming flit offered |
| in_ready | output | 1 | Incoming flit taken |
| in_flit | input | 32 | Incoming flit |
| in_last | input | 1 | Tail flag of incoming flit |
| rsp_valid | output | 1 | Response ready for core |
| rsp_ready | input | 1 | Core takes response |
| rsp_hdr | output | 32 | Response header flit |
| rsp_len | output | 3 | Response data word count |
| rsp_data | output | 128 | Response data words, word 0 lowest |

## Verification
Two events can land on the same edge: acceptance of a new request and delivery of a response. Both move the outstanding count, in opposite directions. The bench provokes this with three requests in flight. It parks a complete response with `rsp_ready` low, then raises `req_valid` and `rsp_ready` in the same cycle. It judges the outcome at the ports: exactly one more request must then be accepted before `req_ready` stays low, which shows the count went back to three and not to two or four.

// File: rtl/noc_ni_pkg.sv
package noc_ni_pkg;
  localparam int FLIT_W  = 32;
  localparam int NODE_W  = 3;
  localparam int HOPS    = 4;
  localparam int PORT_W  = 2;
  localparam int ROUTE_W = HOPS * PORT_W;
  localparam int NUM_DEST = 1 << NODE_W;

  typedef struct packed {
    logic [4:0]         pad;
    logic [2:0]         nwords;
    logic [3:0]         pidx;
    logic [3:0]         bid;
    logic [1:0]         cmd;
    logic [NODE_W-1:0]  src;
    logic [NODE_W-1:0]  dst;
    logic [ROUTE_W-1:0] route;
  } hdr_t;

  function automatic logic [ROUTE_W-1:0] route_of(input int d);
    logic [ROUTE_W-1:0] r;
    r = '0;
    for (int k = 0; k < HOPS; k++) r[k*PORT_W +: PORT_W] = PORT_W'((d + k) % (1 << PORT_W));
    return r;
  endfunction
endpackage

// File: rtl/noc_ni_route_lut.sv
module noc_ni_route_lut
  import noc_ni_pkg::*;
(
  input  logic [NODE_W-1:0]  dest,
  output logic [ROUTE_W-1:0] route
);
  logic [ROUTE_W-1:0] tbl [NUM_DEST];

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_ent
    assign tbl[g] = route_of(g);
  end

  assign route = tbl[dest];
endmodule

// File: rtl/noc_ni_tx.sv
module noc_ni_tx
  import noc_ni_pkg::*;
#(
  parameter int MAX_BEATS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [FLIT_W-1:0]             hdr,
  input  logic [FLIT_W-1:0]             addr,
  input  logic [$clog2(MAX_BEATS+1)-1:0] len,
  input  logic [MAX_BEATS*FLIT_W-1:0]   data,
  output logic                          busy,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [FLIT_W-1:0]             out_flit,
  output logic                          out_last
);
  localparam int LEN_W  = $clog2(MAX_BEATS + 1);
  localparam int IDX_W  = $clog2(MAX_BEATS + 2);
  localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  logic [IDX_W-1:0]                    idx;
  logic [FLIT_W-1:0]                   hdr_q, addr_q;
  logic [LEN_W-1:0]                    len_q;
  logic [MAX_BEATS-1:0][FLIT_W-1:0]    data_q;
  logic [BEAT_W-1:0]                   beat;
  logic                                last_w;

  assign last_w = (idx == IDX_W'(len_q) + IDX_W'(1));
  assign beat   = BEAT_W'(idx - IDX_W'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      idx    <= '0;
      hdr_q  <= hdr;
      addr_q <= addr;
      len_q  <= len;
      data_q <= data;
    end else if (busy && out_ready) begin
      if (last_w) busy <= 1'b0;
      else        idx  <= idx + IDX_W'(1);
    end
  end

  always_comb begin
    if (idx == '0)               out_flit = hdr_q;
    else if (idx == IDX_W'(1))   out_flit = addr_q;
    else                         out_flit = data_q[beat];
  end

  assign out_valid = busy;
  assign out_last  = busy && last_w;

  AST_FLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_flit) && $stable(out_last)); // R5
  AST_TAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid); // R4
endmodule

// File: rtl/noc_ni_rx.sv
module noc_ni_rx
  import noc_ni_pkg::*;
#(
  parameter int MAX_BEATS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [FLIT_W-1:0]              in_flit,
  input  logic                           in_last,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [FLIT_W-1:0]              rsp_hdr,
  output logic [$clog2(MAX_BEATS+1)-1:0] rsp_len,
  output logic [MAX_BEATS*FLIT_W-1:0]    rsp_data
);
  localparam int LEN_W  = $clog2(MAX_BEATS + 1);
  localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  logic                              full, mid, fire;
  logic [LEN_W-1:0]                  cnt_q;
  logic [MAX_BEATS-1:0][FLIT_W-1:0]  data_q;

  assign in_ready = !full;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      mid   <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (full && rsp_ready) full <= 1'b0;
      if (fire) begin
        if (!mid) begin
          rsp_hdr <= in_flit;
          cnt_q   <= '0;
          if (in_last) full <= 1'b1;
          else         mid  <= 1'b1;
        end else begin
          if (cnt_q < LEN_W'(MAX_BEATS)) begin
            data_q[BEAT_W'(cnt_q)] <= in_flit;
            cnt_q                  <= cnt_q + LEN_W'(1);
          end
          if (in_last) begin
            full <= 1'b1;
            mid  <= 1'b0;
          end
        end
      end
    end
  end

  assign rsp_valid = full;
  assign rsp_len   = cnt_q;
  assign rsp_data  = data_q;

  AST_RSP_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(in_valid && in_ready && in_last)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hdr) && $stable(rsp_len) && $stable(rsp_data)); // R10
endmodule

// File: rtl/noc_ni_pkt.sv
module noc_ni_pkt
  import noc_ni_pkg::*;
#(
  parameter int MAX_BEATS = 4,
  parameter int MAX_OUT   = 4,
  parameter int NODE_ID   = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [1:0]                     req_cmd,
  input  logic [NODE_W-1:0]              req_dest,
  input  logic [3:0]                     req_bid,
  input  logic [3:0]                     req_pidx,
  input  logic [FLIT_W-1:0]              req_addr,
  input  logic [$clog2(MAX_BEATS+1)-1:0] req_len,
  input  logic [MAX_BEATS*FLIT_W-1:0]    req_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [FLIT_W-1:0]              out_flit,
  output logic                           out_last,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [FLIT_W-1:0]              in_flit,
  input  logic                           in_last,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [FLIT_W-1:0]              rsp_hdr,
  output logic [$clog2(MAX_BEATS+1)-1:0] rsp_len,
  output logic [MAX_BEATS*FLIT_W-1:0]    rsp_data
);
  localparam int OUT_W = $clog2(MAX_OUT + 1);

  logic [ROUTE_W-1:0] route;
  hdr_t               hdr;
  logic               tx_busy, accept, deliver;
  logic [OUT_W-1:0]   out_cnt;

  noc_ni_route_lut u_lut (.dest(req_dest), .route(route));

  always_comb begin
    hdr        = '0;
    hdr.route  = route;
    hdr.dst    = req_dest;
    hdr.src    = NODE_W'(NODE_ID);
    hdr.cmd    = req_cmd;
    hdr.bid    = req_bid;
    hdr.pidx   = req_pidx;
    hdr.nwords = 3'(req_len);
  end

  assign req_ready = !tx_busy && (out_cnt < OUT_W'(MAX_OUT));
  assign accept    = req_valid && req_ready;
  assign deliver   = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) out_cnt <= '0;
    else begin
      case ({accept, deliver})
        2'b10:   out_cnt <= out_cnt + OUT_W'(1);
        2'b01:   if (out_cnt != '0) out_cnt <= out_cnt - OUT_W'(1);
        default: out_cnt <= out_cnt;
      endcase
    end
  end

  noc_ni_tx #(.MAX_BEATS(MAX_BEATS)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(accept), .hdr(hdr), .addr(req_addr),
    .len(req_len), .data(req_data), .busy(tx_busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit(out_flit), .out_last(out_last));

  noc_ni_rx #(.MAX_BEATS(MAX_BEATS)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .in_last(in_last), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hdr(rsp_hdr), .rsp_len(rsp_len), .rsp_data(rsp_data));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OUT_W'(MAX_OUT)); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready); // R6
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && deliver |=> out_cnt == $past(out_cnt)); // R8
endmodule

// File: tb/noc_ni_pkt_test.sv
`timescale 1ns/1ps
module noc_ni_pkt_test;
  localparam int MB = 4;
  localparam int NODE = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, out_ready = 0, in_valid = 0, in_last = 0, rsp_ready = 0;
  logic [1:0] req_cmd = 0;
  logic [2:0] req_dest = 0, req_len = 0;
  logic [3:0] req_bid = 0, req_pidx = 0;
  logic [31:0] req_addr = 0, in_flit = 0;
  logic [MB*32-1:0] req_data = 0;
  logic req_ready, out_valid, out_last, in_ready, rsp_valid;
  logic [31:0] out_flit, rsp_hdr;
  logic [2:0] rsp_len;
  logic [MB*32-1:0] rsp_data;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp_f [0:5];
  int exp_n;

  noc_ni_pkt #(.MAX_BEATS(MB), .MAX_OUT(4), .NODE_ID(NODE)) uut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_route(input int d);
    logic [7:0] r = 0;
    for (int k = 0; k < 4; k++) r = r | (8'((d + k) % 4) << (2 * k));
    return r;
  endfunction

  task automatic do_req(input int d, input int n, input int cmd, input int tag);
    req_dest = 3'(d); req_len = 3'(n); req_cmd = 2'(cmd);
    req_bid = 4'(tag); req_pidx = 4'(tag >> 2);
    req_addr = 32'h4000_0000 + 32'(tag * 64);
    for (int b = 0; b < MB; b++) req_data[b*32 +: 32] = 32'hA000_0000 + 32'(tag * 16 + b);
    exp_f[0] = {5'b0, 3'(n), 4'(tag >> 2), 4'(tag), 2'(cmd), 3'(NODE), 3'(d), exp_route(d)};
    exp_f[1] = req_addr;
    for (int b = 0; b < n; b++) exp_f[b+2] = req_data[b*32 +: 32];
    exp_n = n + 2;
    req_valid = 1;
    begin
      bit f;
      do begin f = req_ready; @(negedge clk); end while (!f);
    end
    req_valid = 0;
  endtask

  task automatic collect(input int seed);
    int i = 0;
    bit hold_pend = 0;
    logic [31:0] hf; logic hl;
    bit saw6 = 0;
    while (i < exp_n) begin
      if (hold_pend) begin
        chk(out_valid && out_flit == hf && out_last == hl, "R5 flit held", out_flit, hf);
        hold_pend = 0;
      end
      if (!saw6 && out_valid) begin
        chk(!req_ready, "R6 ready low while sending", req_ready, 0);
        saw6 = 1;
      end
      out_ready = ((cyc + seed) % 3) != 0;
      if (out_valid && out_ready) begin
        chk(out_flit == exp_f[i], (i == 0) ? "R2 header" : "R3 flit", out_flit, exp_f[i]);
        chk(out_last == (i == exp_n - 1), "R4 tail flag", out_last, (i == exp_n - 1));
        i++;
      end else if (out_valid) begin
        hf = out_flit; hl = out_last; hold_pend = 1;
      end
      @(negedge clk);
    end
    out_ready = 0;
    chk(!out_valid, "R4 valid drops after tail", out_valid, 0);
  endtask

  task automatic send_rsp(input int n, input int tag, input bit hold);
    logic [31:0] h;
    int m;
    h = {5'b0, 3'(n > 7 ? 7 : n), 4'(0), 4'(tag), 2'b10, 3'(tag % 8), 3'(NODE), 8'(tag)};
    for (int k = 0; k <= n; k++) begin
      bit f;
      in_valid = 1; in_last = (k == n);
      in_flit = (k == 0) ? h : 32'hD000_0000 + 32'(tag * 256 + k - 1);
      do begin
        chk(!rsp_valid, "R9 no response before tail", rsp_valid, 0);
        f = in_ready; @(negedge clk);
      end while (!f);
    end
    in_valid = 0; in_last = 0;
    m = (n > MB) ? MB : n;
    chk(rsp_valid, "R9 response after tail", rsp_valid, 1);
    chk(rsp_hdr == h, "R9 header", rsp_hdr, h);
    chk(rsp_len == 3'(m), (n > MB) ? "R11 length capped" : "R9 length", rsp_len, m);
    for (int b = 0; b < m; b++)
      chk(rsp_data[b*32 +: 32] == 32'hD000_0000 + 32'(tag * 256 + b),
          (n > MB) ? "R11 first words kept" : "R9 data", rsp_data[b*32 +: 32], 32'hD000_0000 + 32'(tag * 256 + b));
    if (hold) begin
      logic [127:0] sd = rsp_data;
      in_valid = 1; in_flit = 32'hFFFF_FFFF; in_last = 1;
      @(negedge clk);
      chk(!in_ready, "R10 input stalled", in_ready, 0);
      chk(rsp_valid && rsp_hdr == h && rsp_data == sd, "R10 response held", rsp_hdr, h);
      in_valid = 0; in_last = 0;
    end
  endtask

  task automatic deliver();
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    chk(!rsp_valid, "R10 response released", rsp_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual %0d expected done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 req_ready", req_ready, 1);
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
    chk(in_ready, "R1 in_ready", in_ready, 1);

    for (int d = 0; d < 8; d++)
      for (int n = 0; n <= MB; n++) begin
        do_req(d, n, (d + n) % 4, tag);
        collect(tag);
        send_rsp(tag % 6, tag, tag % 5 == 0);
        deliver();
        tag++;
      end

    for (int j = 0; j < 4; j++) begin
      do_req(j, j, 1, tag); collect(tag); tag++;
    end
    repeat (3) begin
      req_valid = 1;
      chk(!req_ready, "R7 full stalls requests", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 0;
    send_rsp(2, 3, 0);
    chk(!req_ready, "R7 still full before delivery", req_ready, 0);
    deliver();
    chk(req_ready, "R7 ready after delivery", req_ready, 1);

    send_rsp(1, 7, 1);
    req_dest = 3'(2); req_len = 3'(1); req_cmd = 2'(1); req_bid = 4'(tag); req_pidx = 4'(tag >> 2);
    req_addr = 32'h4000_0000 + 32'(tag * 64);
    req_data[31:0] = 32'hA000_0000 + 32'(tag * 16);
    exp_f[0] = {5'b0, 3'd1, 4'(tag >> 2), 4'(tag), 2'd1, 3'(NODE), 3'd2, exp_route(2)};
    exp_f[1] = req_addr; exp_f[2] = req_data[31:0]; exp_n = 3;
    chk(req_ready && rsp_valid, "R8 both sides ready", {req_ready, rsp_valid}, 2'b11);
    req_valid = 1; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0; rsp_ready = 0;
    chk(!rsp_valid, "R8 response delivered", rsp_valid, 0);
    collect(tag); tag++;
    chk(req_ready, "R8 count unchanged, one slot left", req_ready, 1);
    do_req(5, 2, 0, tag); collect(tag); tag++;
    chk(!req_ready, "R8 full after one more", req_ready, 0);

    for (int j = 0; j < 4; j++) begin send_rsp(0, j, 0); deliver(); end
    chk(req_ready, "R7 drained", req_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule